// File: doc/BRIEF.md
# Configurable Cache Set-Index Generator

This block turns a physical address into the set index of an L1 data cache. Three index functions are available. The plain linear index takes the line-address bits. The XOR-fold hash spreads strided traffic across the sets. The polynomial hash uses fixed XOR equations over address bits 7 to 26. A fourth code is reserved for a custom function and, for now, returns the linear result. The line size is a build-time parameter, given as `LINE_LOG2`. The number of sets is chosen at run time as a log2 value.

A request carries the address, a mode code and the set-count log2. It is accepted on a valid/ready handshake. The result comes out of an output register one cycle later, and a new request can be taken every cycle while the consumer is ready. A set count or mode code that the selected function cannot serve does not produce an index. In that case the error flag is raised and the index reads zero.

Top module: `set_index_hash`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: Mode code 0 (linear) gives index = (addr >> LINE_LOG2) masked to the low `setsLog2` bits. Any `setsLog2` from 0 to IDX_W (6) is legal.
- R3: Mode code 1 (XOR fold) gives index = ((addr >> LINE_LOG2) XOR (addr >> (LINE_LOG2 + setsLog2))) masked to the low `setsLog2` bits.
- R4: Mode code 2 (polynomial) sets index bits 0 to 4 as XORs of these address bits:
  - bit 0: {7,12,15,17,18,21,22,23,24,25}
  - bit 1: {8,13,16,18,19,22,23,24,25,26}
  - bit 2: {9,12,14,15,18,19,20,21,22,26}
  - bit 3: {10,13,15,16,19,20,21,22,23}
  - bit 4: {11,14,16,17,20,21,22,23,24}
- R5: In mode code 2, index bit 5 equals address bit 12 when `setsLog2` = 6, and is 0 when `setsLog2` = 5.
- R6: Mode code 3 (reserved custom) returns exactly the linear result of R2, including its error behaviour.
- R7: The hash modes (codes 1 and 2) flag an error unless `setsLog2` is 5 or 6. The linear and custom codes flag an error when `setsLog2` exceeds 6.
- R8: Mode codes 4 to 7 are undefined, and each one flags an error.
- R9: Whenever `outErr` is 1, `outIndex` is 0.
- R10: A request accepted at a clock edge shows `outValid` with its result after that edge. With `outReady` held high, one request is accepted on every clock edge.
- R11: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and `outIndex` and `outErr` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| inAddr | input | 64 | Physical address |
| inMode | input | 3 | Index function code (0 linear, 1 XOR fold, 2 polynomial, 3 custom, 4-7 undefined) |
| inSetsLog2 | input | 3 | log2 of the set count |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outIndex | output | 6 | Set index |
| outErr | output | 1 | Configuration error for this request |

## Verification
The linear and custom codes are driven with several set counts, from 1 set to 64 sets. This separates a correct mask from an off-by-one mask. The polynomial mode is driven with one-hot addresses that walk bits 7 to 26 under both 32 and 64 sets, which isolates every tap of every index bit and the two behaviours of bit 5. Random addresses in all three functions then catch errors in how the taps combine. A pass with a random `outReady` separates the hold-under-stall behaviour from the full-rate, one-cycle-latency behaviour. Error cases cover hash modes with 16 and 128 sets, linear with 128 sets, and every undefined code.

// File: rtl/shx_pkg.sv
package shx_pkg;
  typedef enum logic [2:0] {
    MODE_LINEAR = 3'd0,
    MODE_XFOLD  = 3'd1,
    MODE_IPOLY  = 3'd2,
    MODE_CUSTOM = 3'd3
  } modeE;

  typedef struct packed {
    logic load;
    logic hold;
  } strobeT;
endpackage

// File: rtl/shx_ctrl.sv
module shx_ctrl
  import shx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  output logic   inReady,
  output logic   outValid,
  input  logic   outReady,
  output strobeT strobe
);
  logic validQ;

  assign inReady     = !validQ || outReady;
  assign strobe.load = inValid && inReady;
  assign strobe.hold = validQ && !outReady;
  assign outValid    = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.load) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid) else $error("accept lost"); // R10

  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid) else $error("stall dropped result"); // R11

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !strobe.load) else $error("load during stall"); // R11
endmodule

// File: rtl/shx_datapath.sv
module shx_datapath
  import shx_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int IDX_W     = 6,
  parameter int LINE_LOG2 = 7,
  parameter int SETS_W    = 3,
  parameter int MODE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [MODE_W-1:0] inMode,
  input  logic [SETS_W-1:0] inSetsLog2,
  output logic [IDX_W-1:0]  outIndex,
  output logic              outErr
);
  localparam int HASH_LO = 5;
  localparam int HASH_HI = 6;
  localparam int TAP_W   = 32;
  localparam int IPOLY_N = 5;

  function automatic logic [TAP_W-1:0] tapOf(input int bitNo);
    case (bitNo)
      0:       tapOf = 32'h03E6_9080;
      1:       tapOf = 32'h07CD_2100;
      2:       tapOf = 32'h047C_D200;
      3:       tapOf = 32'h00F9_A400;
      4:       tapOf = 32'h01F3_4800;
      default: tapOf = '0;
    endcase
  endfunction

  logic [ADDR_W-1:0] lineAddr;
  logic [ADDR_W-1:0] upperAddr;
  logic [IDX_W-1:0]  setMask;
  logic [IDX_W-1:0]  linIdx;
  logic [IDX_W-1:0]  foldIdx;
  logic [IDX_W-1:0]  polyIdx;
  logic [IDX_W-1:0]  selIdx;
  logic              hashOk;
  logic              cfgErr;
  logic [IDX_W-1:0]  idxQ;
  logic              errQ;

  assign lineAddr  = inAddr >> LINE_LOG2;
  assign upperAddr = inAddr >> (LINE_LOG2 + int'(inSetsLog2));

  genvar gi;
  generate
    for (gi = 0; gi < IDX_W; gi++) begin : g_bits
      assign setMask[gi] = (gi < int'(inSetsLog2));
      if (gi < IPOLY_N) begin : g_tap
        assign polyIdx[gi] = ^(inAddr[TAP_W-1:0] & tapOf(gi));
      end else if (gi == IPOLY_N) begin : g_top
        assign polyIdx[gi] = (int'(inSetsLog2) == HASH_HI) && inAddr[12];
      end else begin : g_zero
        assign polyIdx[gi] = 1'b0;
      end
    end
  endgenerate

  assign linIdx  = lineAddr[IDX_W-1:0] & setMask;
  assign foldIdx = (lineAddr[IDX_W-1:0] ^ upperAddr[IDX_W-1:0]) & setMask;
  assign hashOk  = (int'(inSetsLog2) == HASH_LO) || (int'(inSetsLog2) == HASH_HI);

  always_comb begin
    cfgErr = 1'b0;
    selIdx = '0;
    case (inMode)
      MODE_LINEAR, MODE_CUSTOM: begin
        cfgErr = int'(inSetsLog2) > IDX_W;
        selIdx = linIdx;
      end
      MODE_XFOLD: begin
        cfgErr = !hashOk;
        selIdx = foldIdx;
      end
      MODE_IPOLY: begin
        cfgErr = !hashOk;
        selIdx = polyIdx;
      end
      default: cfgErr = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      errQ <= 1'b0;
    end else if (strobe.load) begin
      idxQ <= cfgErr ? '0 : selIdx;
      errQ <= cfgErr;
    end
  end

  assign outIndex = idxQ;
  assign outErr   = errQ;

  AST_ERR_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (idxQ == '0)) else $error("error with nonzero index"); // R9

  AST_BAD_MODE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inMode > 3'd3) |=> errQ) else $error("undefined mode accepted"); // R8

  AST_POLY32_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inMode == 3'd2 && int'(inSetsLog2) == HASH_LO) |=> ((idxQ >> IPOLY_N) == '0))
    else $error("32-set polynomial index too wide"); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> ($stable(idxQ) && $stable(errQ))) else $error("result changed under stall"); // R11
endmodule

// File: rtl/set_index_hash.sv
module set_index_hash
  import shx_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int IDX_W     = 6,
  parameter int LINE_LOG2 = 7,
  parameter int SETS_W    = 3,
  parameter int MODE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [MODE_W-1:0] inMode,
  input  logic [SETS_W-1:0] inSetsLog2,
  output logic              outValid,
  input  logic              outReady,
  output logic [IDX_W-1:0]  outIndex,
  output logic              outErr
);
  strobeT strobe;

  shx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  shx_datapath #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .LINE_LOG2 (LINE_LOG2),
    .SETS_W    (SETS_W),
    .MODE_W    (MODE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inAddr     (inAddr),
    .inMode     (inMode),
    .inSetsLog2 (inSetsLog2),
    .outIndex   (outIndex),
    .outErr     (outErr)
  );
endmodule

// File: tb/set_index_hash_test.sv
`timescale 1ns/1ps
module set_index_hash_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inAddr = '0;
  logic [2:0]  inMode = '0;
  logic [2:0]  inSetsLog2 = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [5:0]  outIndex;
  logic        outErr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit stallMode = 0;
  bit done = 0;

  typedef struct {
    logic [5:0] idx;
    logic       err;
    int         acc;
    bit         fast;
    string      req;
  } itemT;
  itemT sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  set_index_hash uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inMode(inMode), .inSetsLog2(inSetsLog2),
    .outValid(outValid), .outReady(outReady), .outIndex(outIndex), .outErr(outErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] a, input logic [2:0] m, input logic [2:0] s,
                                output logic [5:0] idx, output logic e);
    logic [63:0] mask;
    logic [5:0] lin, fold, poly;
    mask = (64'd1 << s) - 64'd1;
    lin  = 6'((a >> 7) & mask);
    fold = 6'(((a >> 7) ^ (a >> (7 + int'(s)))) & mask);
    poly[0] = a[7]^a[12]^a[15]^a[17]^a[18]^a[21]^a[22]^a[23]^a[24]^a[25];
    poly[1] = a[8]^a[13]^a[16]^a[18]^a[19]^a[22]^a[23]^a[24]^a[25]^a[26];
    poly[2] = a[9]^a[12]^a[14]^a[15]^a[18]^a[19]^a[20]^a[21]^a[22]^a[26];
    poly[3] = a[10]^a[13]^a[15]^a[16]^a[19]^a[20]^a[21]^a[22]^a[23];
    poly[4] = a[11]^a[14]^a[16]^a[17]^a[20]^a[21]^a[22]^a[23]^a[24];
    poly[5] = (s == 3'd6) ? a[12] : 1'b0;
    case (m)
      3'd0, 3'd3: begin e = (s > 3'd6); idx = lin; end
      3'd1:       begin e = !(s == 3'd5 || s == 3'd6); idx = fold; end
      3'd2:       begin e = !(s == 3'd5 || s == 3'd6); idx = poly; end
      default:    begin e = 1'b1; idx = '0; end
    endcase
    if (e) idx = '0;
  endfunction

  task automatic send(input logic [63:0] a, input logic [2:0] m, input logic [2:0] s, input string req);
    itemT it;
    @(negedge clk);
    inAddr = a; inMode = m; inSetsLog2 = s; inValid = 1'b1;
    #0.6;
    while (!inReady) begin
      @(negedge clk);
      #0.6;
    end
    model(a, m, s, it.idx, it.err);
    it.acc = cyc + 1;
    it.fast = !stallMode;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    bit prevStall = 0;
    logic [5:0] prevIdx = '0;
    logic prevErr = 0;
    forever begin
      @(negedge clk);
      outReady = stallMode ? 1'($urandom % 2) : 1'b1;
      #0.3;
      if (rstN) begin
        if (prevStall) begin
          check(outValid && outIndex == prevIdx && outErr == prevErr, "R11", "hold",
                {outValid, outErr, outIndex}, {1'b1, prevErr, prevIdx});
        end
        if (outValid && !outReady)
          check(!inReady, "R11", "inReady in stall", inReady, 0);
        prevStall = outValid && !outReady;
        prevIdx = outIndex;
        prevErr = outErr;
        if (outValid && outReady) begin
          if (sb.size() == 0) begin
            check(0, "R10", "unexpected result", outIndex, 0);
          end else begin
            itemT it;
            it = sb.pop_front();
            check(outIndex == it.idx && outErr == it.err, it.req, "index/err",
                  {outErr, outIndex}, {it.err, it.idx});
            if (outErr) check(outIndex == 0, "R9", "index under error", outIndex, 0);
            if (it.fast) check(cyc == it.acc, "R10", "latency", cyc, it.acc);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #0.3;
    check(!outValid, "R1", "outValid at reset", outValid, 0);
    check(inReady, "R1", "inReady at reset", inReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    #0.3;
    check(!outValid && inReady, "R1", "after release", {outValid, inReady}, 2'b01);

    // R2 linear with several set counts
    for (int s = 0; s <= 6; s++) begin
      send(64'h0000_1234_5678_9ABC, 3'd0, 3'(s), "R2");
      send(64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'(s), "R2");
    end
    // R6 custom equals linear
    for (int s = 0; s <= 6; s += 3) send(64'hDEAD_BEEF_CAFE_F00D, 3'd3, 3'(s), "R6");
    send(64'h0, 3'd3, 3'd7, "R6");
    // R3 XOR fold
    for (int k = 0; k < 10; k++) send({$urandom, $urandom}, 3'd1, 3'd5, "R3");
    for (int k = 0; k < 10; k++) send({$urandom, $urandom}, 3'd1, 3'd6, "R3");
    // R4/R5 one-hot walk
    for (int b = 7; b <= 26; b++) begin
      send(64'd1 << b, 3'd2, 3'd5, "R4");
      send(64'd1 << b, 3'd2, 3'd6, "R5");
    end
    for (int k = 0; k < 20; k++) send({$urandom, $urandom}, 3'd2, 3'(5 + (k % 2)), "R4");
    // R7 illegal set counts
    send(64'h1F80, 3'd1, 3'd4, "R7");
    send(64'h1F80, 3'd1, 3'd7, "R7");
    send(64'h1F80, 3'd2, 3'd4, "R7");
    send(64'h1F80, 3'd2, 3'd0, "R7");
    send(64'h1F80, 3'd0, 3'd7, "R7");
    // R8 undefined modes
    for (int m = 4; m < 8; m++) send(64'hFFFF_F000, 3'(m), 3'd6, "R8");
    drain();

    // stalls (R11)
    stallMode = 1;
    for (int k = 0; k < 60; k++)
      send({$urandom, $urandom}, 3'(k % 4), 3'(5 + (k % 2)), "R11");
    drain();
    stallMode = 0;
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R10", "scoreboard empty", sb.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule